// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address by fetching descriptors from a two-level translation table held in memory. A request carries the virtual address, a user/kernel flag and a read/write flag. The walker reads one first-level entry from a 16 KB table whose location comes from a base input. That entry either maps a 1 MB section directly or points to a coarse (1 KB) or fine (4 KB) second-level table. In the second case the walker reads one more entry, which maps a 64 KB large, 4 KB small or 1 KB tiny page.

Once the mapping is known, the walker looks up the two-bit access code of the mapping's domain in a 32-bit domain control word. A domain can deny all access, bypass permission checks, or require the mapping's two-bit permission field to allow the access. For large and small pages that permission field is chosen per subpage. The result is a one-cycle response with the physical address, the bufferable and cacheable attributes, a fault code and the domain involved.

Memory is reached through a single-outstanding read port. The walker holds a read request with a stable address until the memory acknowledges it with data, however many wait cycles that takes. A new translation is taken only while the walker is idle.

Top module: `xlat_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `mem_req` and `rsp_valid` are 0.
- R2: A request is accepted only on a clock edge where `req_ready` is 1 and `req_valid` is 1. While a walk is in progress, `req_valid`, `req_va` and the mode inputs have no effect on the walk or on its response.
- R3: The first memory read uses address {`tbl_base`, VA[31:20], 2'b00}. `mem_req` stays high with a stable `mem_addr` until a cycle with `mem_ack`, after any number of wait cycles. A response never appears without a preceding acknowledge.
- R4: The first-level type field is bits [1:0]: 0 invalid, 1 coarse table, 2 section, 3 fine table. An invalid entry ends the walk with fault code 1 and domain 0, after exactly one read.
- R5: A section maps PA = {D[31:20], VA[19:0]}. The bufferable bit is D[2], the cacheable bit is D[3], the domain is D[8:5] and the permission field is D[11:10].
- R6: The second read address is {D[31:10], VA[19:12], 2'b00} for a coarse entry and {D[31:12], VA[19:10], 2'b00} for a fine entry. In both cases the domain is D[8:5] of the first-level entry.
- R7: The second-level type field is bits [1:0]: 0 invalid, 1 large page, 2 small page, 3 tiny page. An invalid entry, or a tiny entry reached through a coarse table, gives fault code 2 with the first-level domain.
- R8: The page PA is {P[31:16], VA[15:0]} for a large page, {P[31:12], VA[11:0]} for a small page and {P[31:10], VA[9:0]} for a tiny page. The bufferable bit is P[2] and the cacheable bit is P[3].
- R9: For a large page the permission field is P[2k+5:2k+4] with k = VA[15:14]. For a small page k = VA[11:10]. A tiny page always uses P[5:4].
- R10: The domain access code is `dom_ctrl`[2d+1:2d] for domain d. Codes 0 and 2 give fault code 3. Code 3 grants any access. Code 1 applies the permission check.
- R11: Under a checked domain, kernel reads are always allowed. A kernel write needs a permission field other than 0. A user read needs field bit 1 set. A user write needs a field of 3. Any other access gives fault code 4.
- R12: `rsp_valid` is high for exactly one cycle per accepted request, one cycle after the final acknowledge. With fault code 0 (no fault), the outputs carry the mapping. With any other code, `rsp_pa`, `rsp_bufferable` and `rsp_cacheable` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 32 | Virtual address to translate |
| req_user | input | 1 | 1 for user mode, 0 for kernel mode |
| req_write | input | 1 | 1 for write access, 0 for read |
| tbl_base | input | 18 | Physical address bits [31:14] of the first-level table |
| dom_ctrl | input | 32 | Two-bit access code for each of 16 domains |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 32 | Word address of the descriptor to read |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Descriptor returned by memory |
| rsp_valid | output | 1 | Response pulse |
| rsp_pa | output | 32 | Translated physical address (0 on fault) |
| rsp_fault | output | 3 | 0 none, 1 first-level translation, 2 second-level translation, 3 domain, 4 permission |
| rsp_dom | output | 4 | Domain of the mapping (0 for a first-level translation fault) |
| rsp_bufferable | output | 1 | Bufferable attribute (0 on fault) |
| rsp_cacheable | output | 1 | Cacheable attribute (0 on fault) |

## Verification
Assertions watch the memory handshake and the response on every cycle. They check that a pending read keeps its address until acknowledged, that each response is a single-cycle pulse following an acknowledge, that a faulting response carries no address or attributes, and that a first-level translation fault reports domain 0.

The address arithmetic for every granularity, the subpage permission select and the full domain and permission decision table only show up in the bench. The bench sweeps every combination of first-level type, second-level type, domain code and access mode over random descriptors, addresses and memory wait times. It also holds junk requests on the input during walks.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W    = 32;
  localparam int DOM_W   = 4;
  localparam int N_DOM   = 1 << DOM_W;
  localparam int DAC_W   = 2 * N_DOM;
  localparam int L1_IDXW = 12;
  localparam int BASE_W  = VA_W - L1_IDXW - 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_L1   = 2'd1,
    ST_L2   = 2'd2,
    ST_DONE = 2'd3
  } walk_state_e;

  typedef enum logic [1:0] {
    L1_INV     = 2'd0,
    L1_COARSE  = 2'd1,
    L1_SECTION = 2'd2,
    L1_FINE    = 2'd3
  } l1_kind_e;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_XLAT_L1 = 3'd1,
    FLT_XLAT_L2 = 3'd2,
    FLT_DOMAIN  = 3'd3,
    FLT_PERM    = 3'd4
  } fault_e;
endpackage

// File: rtl/xlat_l1_decode.sv
module xlat_l1_decode
  import xlat_pkg::*;
(
  input  logic [31:0]      desc,
  input  logic [19:0]      va_lo,
  output l1_kind_e         kind,
  output logic [31:0]      sect_pa,
  output logic [31:0]      l2_addr,
  output logic [DOM_W-1:0] dom,
  output logic [1:0]       ap,
  output logic             buf_en,
  output logic             cache_en
);
  logic unused_bits;
  assign unused_bits = ^{desc[9], desc[4]};

  assign kind     = l1_kind_e'(desc[1:0]);
  assign sect_pa  = {desc[31:20], va_lo};
  assign dom      = desc[8:5];
  assign ap       = desc[11:10];
  assign buf_en   = desc[2];
  assign cache_en = desc[3];

  // fine tables use 1 KB granules (1024 entries), coarse ones 4 KB (256 entries)
  always_comb begin
    if (desc[1:0] == 2'b11) l2_addr = {desc[31:12], va_lo[19:10], 2'b00};
    else                    l2_addr = {desc[31:10], va_lo[19:12], 2'b00};
  end
endmodule

// File: rtl/xlat_l2_decode.sv
module xlat_l2_decode (
  input  logic [31:0] desc,
  input  logic [15:0] va_lo,
  input  logic        fine,
  output logic        ok,
  output logic [31:0] pa,
  output logic [1:0]  ap,
  output logic        buf_en,
  output logic        cache_en
);
  logic [1:0] sub_sel;

  assign buf_en   = desc[2];
  assign cache_en = desc[3];
  assign ok       = (desc[1:0] != 2'b00) && !((desc[1:0] == 2'b11) && !fine);

  always_comb begin
    unique case (desc[1:0])
      2'b01: begin pa = {desc[31:16], va_lo[15:0]}; sub_sel = va_lo[15:14]; end
      2'b10: begin pa = {desc[31:12], va_lo[11:0]}; sub_sel = va_lo[11:10]; end
      2'b11: begin pa = {desc[31:10], va_lo[9:0]};  sub_sel = 2'b00;        end
      default: begin pa = '0; sub_sel = 2'b00; end
    endcase
  end

  always_comb begin
    unique case (sub_sel)
      2'd0: ap = desc[5:4];
      2'd1: ap = desc[7:6];
      2'd2: ap = desc[9:8];
      default: ap = desc[11:10];
    endcase
  end
endmodule

// File: rtl/xlat_access_check.sv
module xlat_access_check
  import xlat_pkg::*;
(
  input  logic [DAC_W-1:0] dac,
  input  logic [DOM_W-1:0] dom,
  input  logic [1:0]       ap,
  input  logic             is_user,
  input  logic             is_write,
  output fault_e           fault
);
  logic [1:0] dcode;
  logic       granted;

  assign dcode = dac[{dom, 1'b0} +: 2];

  always_comb begin
    if (is_user) granted = is_write ? (ap == 2'b11) : ap[1];
    else         granted = !is_write || (ap != 2'b00);
  end

  always_comb begin
    unique case (dcode)
      2'b11:   fault = FLT_NONE;
      2'b01:   fault = granted ? FLT_NONE : FLT_PERM;
      default: fault = FLT_DOMAIN;
    endcase
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_user,
  input  logic              req_write,
  input  logic [BASE_W-1:0] tbl_base,
  input  logic [DAC_W-1:0]  dom_ctrl,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_pa,
  output logic [2:0]        rsp_fault,
  output logic [DOM_W-1:0]  rsp_dom,
  output logic              rsp_bufferable,
  output logic              rsp_cacheable
);
  walk_state_e      state_q, state_d;
  logic [VA_W-1:0]  va_q;
  logic             user_q, write_q, fine_q;
  logic [31:0]      l2_addr_q;
  logic [DOM_W-1:0] dom_q;
  logic [31:0]      pa_q;
  fault_e           fault_q;
  logic [DOM_W-1:0] rdom_q;
  logic             b_q, c_q;

  logic ld_req, ld_l2, ld_res;
  fault_e           res_fault;
  logic [31:0]      res_pa;
  logic [DOM_W-1:0] res_dom;
  logic             res_b, res_c;

  l1_kind_e         l1_kind;
  logic [31:0]      l1_sect_pa, l1_l2_addr;
  logic [DOM_W-1:0] l1_dom;
  logic [1:0]       l1_ap;
  logic             l1_b, l1_c;

  logic             l2_ok;
  logic [31:0]      l2_pa;
  logic [1:0]       l2_ap;
  logic             l2_b, l2_c;

  logic [DOM_W-1:0] chk_dom;
  logic [1:0]       chk_ap;
  fault_e           chk_fault;

  xlat_l1_decode u_l1 (
    .desc(mem_rdata), .va_lo(va_q[19:0]), .kind(l1_kind), .sect_pa(l1_sect_pa),
    .l2_addr(l1_l2_addr), .dom(l1_dom), .ap(l1_ap), .buf_en(l1_b), .cache_en(l1_c)
  );

  xlat_l2_decode u_l2 (
    .desc(mem_rdata), .va_lo(va_q[15:0]), .fine(fine_q), .ok(l2_ok), .pa(l2_pa),
    .ap(l2_ap), .buf_en(l2_b), .cache_en(l2_c)
  );

  assign chk_dom = (state_q == ST_L1) ? l1_dom : dom_q;
  assign chk_ap  = (state_q == ST_L1) ? l1_ap  : l2_ap;

  xlat_access_check u_chk (
    .dac(dom_ctrl), .dom(chk_dom), .ap(chk_ap), .is_user(user_q),
    .is_write(write_q), .fault(chk_fault)
  );

  // next-state and result selection
  always_comb begin
    state_d   = state_q;
    ld_req    = 1'b0;
    ld_l2     = 1'b0;
    ld_res    = 1'b0;
    res_fault = FLT_NONE;
    res_pa    = '0;
    res_dom   = dom_q;
    res_b     = 1'b0;
    res_c     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ld_req  = 1'b1;
          state_d = ST_L1;
        end
      end
      ST_L1: begin
        if (mem_ack) begin
          unique case (l1_kind)
            L1_INV: begin
              ld_res    = 1'b1;
              res_fault = FLT_XLAT_L1;
              res_dom   = '0;
              state_d   = ST_DONE;
            end
            L1_SECTION: begin
              ld_res    = 1'b1;
              res_fault = chk_fault;
              res_dom   = l1_dom;
              if (chk_fault == FLT_NONE) begin
                res_pa = l1_sect_pa;
                res_b  = l1_b;
                res_c  = l1_c;
              end
              state_d = ST_DONE;
            end
            default: begin
              ld_l2   = 1'b1;
              state_d = ST_L2;
            end
          endcase
        end
      end
      ST_L2: begin
        if (mem_ack) begin
          ld_res  = 1'b1;
          state_d = ST_DONE;
          if (!l2_ok) begin
            res_fault = FLT_XLAT_L2;
          end else begin
            res_fault = chk_fault;
            if (chk_fault == FLT_NONE) begin
              res_pa = l2_pa;
              res_b  = l2_b;
              res_c  = l2_c;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q    <= '0;
      user_q  <= 1'b0;
      write_q <= 1'b0;
    end else if (ld_req) begin
      va_q    <= req_va;
      user_q  <= req_user;
      write_q <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l2_addr_q <= '0;
      dom_q     <= '0;
      fine_q    <= 1'b0;
    end else if (ld_l2) begin
      l2_addr_q <= l1_l2_addr;
      dom_q     <= l1_dom;
      fine_q    <= (l1_kind == L1_FINE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q    <= '0;
      fault_q <= FLT_NONE;
      rdom_q  <= '0;
      b_q     <= 1'b0;
      c_q     <= 1'b0;
    end else if (ld_res) begin
      pa_q    <= res_pa;
      fault_q <= res_fault;
      rdom_q  <= res_dom;
      b_q     <= res_b;
      c_q     <= res_c;
    end
  end

  assign req_ready      = (state_q == ST_IDLE);
  assign mem_req        = (state_q == ST_L1) || (state_q == ST_L2);
  assign mem_addr       = (state_q == ST_L2) ? l2_addr_q : {tbl_base, va_q[31:20], 2'b00};
  assign rsp_valid      = (state_q == ST_DONE);
  assign rsp_pa         = pa_q;
  assign rsp_fault      = fault_q;
  assign rsp_dom        = rdom_q;
  assign rsp_bufferable = b_q;
  assign rsp_cacheable  = c_q;

  // a pending read keeps its address until acknowledged
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // responses only follow an acknowledged read
  p_rsp_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_req && mem_ack));

  // response is a single-cycle pulse
  p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // faulting responses carry no address or attributes
  p_fault_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 3'd0) |-> (rsp_pa == '0 && !rsp_bufferable && !rsp_cacheable));

  // first-level translation fault reports domain zero
  p_l1_fault_dom_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 3'd1) |-> (rsp_dom == '0));
endmodule

// File: tb/xlat_walker_test.sv
module xlat_walker_test;
  import xlat_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid, req_ready, req_user, req_write;
  logic [31:0] req_va;
  logic [17:0] tbl_base;
  logic [31:0] dom_ctrl;
  logic        mem_req, mem_ack;
  logic [31:0] mem_addr, mem_rdata;
  logic        rsp_valid, rsp_bufferable, rsp_cacheable;
  logic [31:0] rsp_pa;
  logic [2:0]  rsp_fault;
  logic [3:0]  rsp_dom;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] addr_log [2];
  int          nreads;

  always #4 clk = ~clk;

  xlat_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_user(req_user), .req_write(req_write),
    .tbl_base(tbl_base), .dom_ctrl(dom_ctrl), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
    .rsp_fault(rsp_fault), .rsp_dom(rsp_dom), .rsp_bufferable(rsp_bufferable),
    .rsp_cacheable(rsp_cacheable)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  function automatic bit allow(input logic [1:0] ap, input bit user, input bit wr);
    if (user) return wr ? (ap == 2'b11) : ap[1];
    return !wr || (ap != 2'b00);
  endfunction

  // expected result, from the requirements
  task automatic ref_walk(input logic [31:0] va, input bit user, input bit wr,
                          output int flt, output logic [31:0] pa, output logic [1:0] bc,
                          output logic [3:0] dom, output int reads,
                          output logic [31:0] a1, output logic [31:0] a2);
    logic [31:0] d1, d2;
    logic [1:0]  ap, dcode, k;
    bit          mapped;
    mapped = 1'b0; flt = 0; pa = '0; bc = '0; dom = '0; ap = '0; a2 = '0;
    a1 = {tbl_base, va[31:20], 2'b00};
    d1 = rd(a1); reads = 1;
    if (d1[1:0] == 2'b00) flt = 1;
    else if (d1[1:0] == 2'b10) begin
      dom = d1[8:5]; ap = d1[11:10]; pa = {d1[31:20], va[19:0]}; bc = d1[3:2]; mapped = 1'b1;
    end else begin
      dom = d1[8:5];
      a2 = (d1[1:0] == 2'b11) ? {d1[31:12], va[19:10], 2'b00} : {d1[31:10], va[19:12], 2'b00};
      d2 = rd(a2); reads = 2;
      if (d2[1:0] == 2'b00 || (d2[1:0] == 2'b11 && d1[1:0] != 2'b11)) flt = 2;
      else begin
        if (d2[1:0] == 2'b01) begin pa = {d2[31:16], va[15:0]}; k = va[15:14]; end
        else if (d2[1:0] == 2'b10) begin pa = {d2[31:12], va[11:0]}; k = va[11:10]; end
        else begin pa = {d2[31:10], va[9:0]}; k = 2'd0; end
        ap = d2[4 + 2*k +: 2]; bc = d2[3:2]; mapped = 1'b1;
      end
    end
    if (mapped) begin
      dcode = dom_ctrl[2*dom +: 2];
      if (dcode == 2'b00 || dcode == 2'b10) flt = 3;
      else if (dcode == 2'b01 && !allow(ap, user, wr)) flt = 4;
      if (flt != 0) begin pa = '0; bc = '0; end
    end
  endtask

  // memory responder with random wait cycles
  initial begin
    int wcnt, wtgt;
    mem_ack = 1'b0; mem_rdata = '0; wcnt = 0; wtgt = 0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (rst_n && mem_req) begin
        if (wcnt < wtgt) wcnt++;
        else begin
          mem_ack = 1'b1;
          mem_rdata = rd(mem_addr);
          if (nreads < 2) addr_log[nreads] = mem_addr;
          nreads++;
          wcnt = 0;
          wtgt = int'($urandom % 4);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int flt, reads, to;
    logic [31:0] pa, a1, a2, va, d1, d2;
    logic [1:0]  bc;
    logic [3:0]  dom, rdom;
    string tg;
    bit junk;
    req_valid = 0; req_va = '0; req_user = 0; req_write = 0;
    tbl_base = '0; dom_ctrl = '0; nreads = 0;
    repeat (3) @(negedge clk);
    check("R1", "ready in reset", {31'b0, req_ready}, 32'd1);
    check("R1", "mem_req in reset", {31'b0, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ready after reset", {31'b0, req_ready}, 32'd1);
    check("R1", "rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);

    for (int l1t = 0; l1t < 4; l1t++)
      for (int l2t = 0; l2t < 4; l2t++)
        for (int dc = 0; dc < 4; dc++)
          for (int uw = 0; uw < 4; uw++)
            for (int rep = 0; rep < 4; rep++) begin
              mem.delete();
              tbl_base = 18'($urandom);
              dom_ctrl = $urandom;
              va = $urandom;
              rdom = 4'($urandom);
              dom_ctrl[2*rdom +: 2] = 2'(dc);
              d1 = $urandom; d1[1:0] = 2'(l1t); d1[8:5] = rdom;
              a1 = {tbl_base, va[31:20], 2'b00};
              mem[a1] = d1;
              if (l1t == 1 || l1t == 3) begin
                a2 = (l1t == 3) ? {d1[31:12], va[19:10], 2'b00} : {d1[31:10], va[19:12], 2'b00};
                d2 = $urandom; d2[1:0] = 2'(l2t);
                if (a2 != a1) mem[a2] = d2;
              end
              ref_walk(va, uw[1], uw[0], flt, pa, bc, dom, reads, a1, a2);
              junk = (rep == 3);
              nreads = 0;
              @(negedge clk);
              req_valid = 1'b1; req_va = va; req_user = uw[1]; req_write = uw[0];
              @(negedge clk);
              // R2: junk held on the inputs while busy must be ignored
              req_valid = junk; req_va = ~va; req_user = ~uw[1]; req_write = ~uw[0];
              to = 0;
              while (!rsp_valid && to < 100) begin @(negedge clk); to++; end
              req_valid = 1'b0;
              check("R12", "response seen", {31'b0, rsp_valid}, 32'd1);
              if (junk) tg = "R2";
              else if (flt == 1) tg = "R4";
              else if (flt == 2) tg = "R7";
              else if (flt == 3) tg = "R10";
              else if (flt == 4) tg = "R11";
              else if (l1t == 2) tg = "R10";
              else tg = "R9";
              check(tg, "fault code", {29'b0, rsp_fault}, 32'(flt));
              tg = (l1t == 2) ? "R5" : ((l1t == 0) ? "R4" : "R8");
              check(tg, "physical address", rsp_pa, pa);
              check(tg, "bufferable/cacheable", {30'b0, rsp_cacheable, rsp_bufferable}, {30'b0, bc});
              check("R12", "domain", {28'b0, rsp_dom}, {28'b0, dom});
              check("R3", "first read address", addr_log[0], a1);
              check("R6", "read count", 32'(nreads), 32'(reads));
              if (reads == 2) check("R6", "second read address", addr_log[1], a2);
              @(negedge clk);
              check("R12", "single-cycle response", {31'b0, rsp_valid}, 32'd0);
              check("R2", "idle after response", {31'b0, req_ready}, 32'd1);
            end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule